// File: doc/BRIEF.md
# Weighted Two-Requester Bus Arbiter

This block shares one bus between a transmit DMA engine and a receive DMA engine once their channel owns that bus. Each engine raises a request. The arbiter answers with a registered grant. The engine keeps the grant until it pulses its done input. A new decision is taken only in a cycle when no grant is active, so each grant is followed by at least one idle cycle.

Three plain configuration inputs set the policy. The first selects strict priority or weighted round-robin. The second selects which side is favoured. The third is a ratio code. In weighted mode, a code value k lets the favoured side win k+1 contended decisions in a row before the other side is served once. A code of zero therefore alternates, and the favoured side goes first. A quota counter tracks those wins. A decision where only one side requests does not touch the counter. The counter is cleared whenever the mode or the ratio code changes.

Top module: `dpa_arbiter`

## Requirements
- R1: While rst_n is low at a clock edge, both grants are low after that edge and the quota counter is zero, so the first contended decision after reset follows the start of the pattern in R7.
- R2: When no grant is active and exactly one side requests, that side's grant is high after the next clock edge.
- R3: An active grant stays high until its own done input is high at a clock edge, and it is low after that edge; the other side's done input has no effect on it.
- R4: At most one grant is high in any cycle, and a grant rises only after a cycle in which no grant was high.
- R5: With cfg_fixed = 1, the favoured side wins every contended decision, and cfg_ratio has no effect.
- R6: cfg_tx_fav = 0 makes the receive side favoured, and cfg_tx_fav = 1 makes the transmit side favoured.
- R7: With cfg_fixed = 0 and cfg_ratio = k, contended decisions counted from a cleared counter go to the favoured side at positions n with n mod (k+2) < k+1, and to the other side otherwise. Code 0 gives alternation with the favoured side first.
- R8: A decision with only one side requesting leaves the quota counter unchanged.
- R9: A change of cfg_fixed or cfg_ratio, seen as a difference from the value at the previous clock edge, clears the quota counter. The clear already applies to a contended decision taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fixed | input | 1 | 1 = strict priority, 0 = weighted round-robin |
| cfg_tx_fav | input | 1 | 1 = transmit favoured, 0 = receive favoured |
| cfg_ratio | input | RATIO_W | Ratio code k, favoured share k+1 : 1 |
| tx_req | input | 1 | Transmit side request |
| tx_done | input | 1 | Transmit side end-of-transfer pulse |
| tx_gnt | output | 1 | Transmit side grant |
| rx_req | input | 1 | Receive side request |
| rx_done | input | 1 | Receive side end-of-transfer pulse |
| rx_gnt | output | 1 | Receive side grant |

## Verification
A change of the mode or ratio code can arrive in the same cycle as a contended decision. In that cycle the counter clear must win over the stale count. A directed case builds a count of two under ratio code 3, then moves the code to 1 in the same cycle that both sides request. The bench expects the favoured side to win twice more before the other side is served. A random phase flips the configuration while both sides keep requesting, and a bench model of the requirements judges the grant of every cycle.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

   // side index used for the grant vectors
   localparam int unsigned SIDE_TX = 0;
   localparam int unsigned SIDE_RX = 1;
   localparam int unsigned NUM_SIDES = 2;

   typedef struct packed {
      logic win_tx;
      logic win_rx;
      logic step_fav;
      logic step_other;
   } pick_t;

endpackage

// File: rtl/dpa_cfg_watch.sv
module dpa_cfg_watch #(
   parameter int unsigned RATIO_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_fixed,
   input  logic [RATIO_W-1:0] ratio,
   output logic               cfg_changed
);

   logic               mode_q;
   logic [RATIO_W-1:0] ratio_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= 1'b0;
         ratio_q <= '0;
      end else begin
         mode_q  <= mode_fixed;
         ratio_q <= ratio;
      end
   end

   assign cfg_changed = (mode_fixed != mode_q) || (ratio != ratio_q);

endmodule

// File: rtl/dpa_weight_ctr.sv
module dpa_weight_ctr #(
   parameter int unsigned RATIO_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               step_fav,
   input  logic               step_other,
   output logic               quota_met
);

   localparam int unsigned CNT_W   = RATIO_W + 1;
   localparam int unsigned MAX_LIM = 1 << RATIO_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_eff;
   logic [CNT_W-1:0] limit;

   assign limit     = {1'b0, ratio} + CNT_W'(1);
   assign cnt_eff   = clr ? '0 : cnt_q;
   assign quota_met = (cnt_eff >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (step_fav) begin
         cnt_q <= cnt_eff + CNT_W'(1);
      end else if (step_other) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_eff;
      end
   end

   // R7
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MAX_LIM))
      else $error("quota counter above its largest limit");

   // R7
   step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_fav && step_other))
      else $error("favoured and other step in one cycle");

   // R9
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !step_fav) |=> (cnt_q == '0))
      else $error("configuration change did not clear the counter");

endmodule

// File: rtl/dpa_pick.sv
module dpa_pick
   import dpa_pkg::*;
(
   input  logic  idle,
   input  logic  tx_req,
   input  logic  rx_req,
   input  logic  mode_fixed,
   input  logic  tx_fav,
   input  logic  quota_met,
   output pick_t pick
);

   logic both;
   logic fav_wins;

   assign both     = tx_req && rx_req;
   assign fav_wins = mode_fixed || !quota_met;

   always_comb begin
      pick = '0;
      if (idle) begin
         if (both) begin
            // favoured side is tx when tx_fav, rx otherwise
            pick.win_tx     = fav_wins ? tx_fav : !tx_fav;
            pick.win_rx     = fav_wins ? !tx_fav : tx_fav;
            pick.step_fav   = !mode_fixed && !quota_met;
            pick.step_other = !mode_fixed && quota_met;
         end else begin
            pick.win_tx = tx_req;
            pick.win_rx = rx_req;
         end
      end
   end

endmodule

// File: rtl/dpa_grant_reg.sv
module dpa_grant_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic win,
   input  logic done,
   output logic gnt
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt <= 1'b0;
      end else if (gnt) begin
         gnt <= !done;
      end else begin
         gnt <= win;
      end
   end

   // R3
   hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt && !done) |=> gnt)
      else $error("grant dropped without its done pulse");

   // R3
   release_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt && done) |=> !gnt)
      else $error("grant kept after its done pulse");

endmodule

// File: rtl/dpa_arbiter.sv
module dpa_arbiter
   import dpa_pkg::*;
#(
   parameter int unsigned RATIO_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_fixed,
   input  logic               cfg_tx_fav,
   input  logic [RATIO_W-1:0] cfg_ratio,
   input  logic               tx_req,
   input  logic               tx_done,
   output logic               tx_gnt,
   input  logic               rx_req,
   input  logic               rx_done,
   output logic               rx_gnt
);

   generate
      if (RATIO_W < 1 || RATIO_W > 4) begin : g_bad_ratio_w
         $error("RATIO_W must lie between 1 and 4");
      end
   endgenerate

   logic                 cfg_changed;
   logic                 quota_met;
   logic                 idle;
   pick_t                pick;
   logic [NUM_SIDES-1:0] win_v;
   logic [NUM_SIDES-1:0] done_v;
   logic [NUM_SIDES-1:0] gnt_v;

   assign idle = (gnt_v == '0);

   dpa_cfg_watch #(.RATIO_W(RATIO_W)) u_watch (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_fixed  (cfg_fixed),
      .ratio       (cfg_ratio),
      .cfg_changed (cfg_changed)
   );

   dpa_weight_ctr #(.RATIO_W(RATIO_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (cfg_changed),
      .ratio      (cfg_ratio),
      .step_fav   (pick.step_fav),
      .step_other (pick.step_other),
      .quota_met  (quota_met)
   );

   dpa_pick u_pick (
      .idle       (idle),
      .tx_req     (tx_req),
      .rx_req     (rx_req),
      .mode_fixed (cfg_fixed),
      .tx_fav     (cfg_tx_fav),
      .quota_met  (quota_met),
      .pick       (pick)
   );

   assign win_v[SIDE_TX]  = pick.win_tx;
   assign win_v[SIDE_RX]  = pick.win_rx;
   assign done_v[SIDE_TX] = tx_done;
   assign done_v[SIDE_RX] = rx_done;

   generate
      for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
         dpa_grant_reg u_gnt (
            .clk   (clk),
            .rst_n (rst_n),
            .win   (win_v[s]),
            .done  (done_v[s]),
            .gnt   (gnt_v[s])
         );
      end
   endgenerate

   assign tx_gnt = gnt_v[SIDE_TX];
   assign rx_gnt = gnt_v[SIDE_RX];

   // R4
   single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_gnt, rx_gnt}))
      else $error("both grants high");

   // R4
   idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tx_gnt) || $rose(rx_gnt)) |-> $past(!tx_gnt && !rx_gnt))
      else $error("grant rose without an idle cycle before it");

   // R2
   lone_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_gnt && !rx_gnt && tx_req && !rx_req) |=> tx_gnt)
      else $error("lone transmit request not granted");

   // R2
   lone_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_gnt && !rx_gnt && rx_req && !tx_req) |=> rx_gnt)
      else $error("lone receive request not granted");

   // R5
   fixed_tx_fav_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_gnt && !rx_gnt && tx_req && rx_req && cfg_fixed && cfg_tx_fav) |=> tx_gnt)
      else $error("fixed mode did not favour transmit");

   // R6
   fixed_rx_fav_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_gnt && !rx_gnt && tx_req && rx_req && cfg_fixed && !cfg_tx_fav) |=> rx_gnt)
      else $error("fixed mode did not favour receive");

endmodule

// File: tb/dpa_arbiter_tb.sv
`timescale 1ns/1ps
module dpa_arbiter_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_fixed = 1'b0;
   logic       cfg_tx_fav = 1'b0;
   logic [1:0] cfg_ratio = 2'd0;
   logic       tx_req = 1'b0;
   logic       tx_done = 1'b0;
   logic       rx_req = 1'b0;
   logic       rx_done = 1'b0;
   logic       tx_gnt;
   logic       rx_gnt;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // bench model state: 0 none, 1 tx, 2 rx
   int         m_own = 0;
   int         m_cnt = 0;
   logic       m_fix_prev = 1'b0;
   logic [1:0] m_rat_prev = 2'd0;

   always #2 clk = ~clk;

   dpa_arbiter #(.RATIO_W(2)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_fixed  (cfg_fixed),
      .cfg_tx_fav (cfg_tx_fav),
      .cfg_ratio  (cfg_ratio),
      .tx_req     (tx_req),
      .tx_done    (tx_done),
      .tx_gnt     (tx_gnt),
      .rx_req     (rx_req),
      .rx_done    (rx_done),
      .rx_gnt     (rx_gnt)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_winner(input int n, input bit fixed, input bit txfav, input int k);
      int fav;
      fav = txfav ? 1 : 2;
      if (fixed) return fav;
      return ((n % (k + 2)) < (k + 1)) ? fav : 3 - fav;
   endfunction

   function automatic int dut_owner();
      return tx_gnt ? 1 : (rx_gnt ? 2 : 0);
   endfunction

   task automatic model_edge();
      bit changed;
      int eff;
      int nxt;
      int fav;
      changed = (cfg_fixed != m_fix_prev) || (cfg_ratio != m_rat_prev);
      eff = changed ? 0 : m_cnt;
      nxt = eff;
      if (!rst_n) begin
         m_own = 0; m_cnt = 0; m_fix_prev = 1'b0; m_rat_prev = 2'd0;
         return;
      end
      if (m_own == 1) begin
         if (tx_done) m_own = 0;
      end else if (m_own == 2) begin
         if (rx_done) m_own = 0;
      end else if (tx_req && rx_req) begin
         fav = cfg_tx_fav ? 1 : 2;
         if (cfg_fixed) m_own = fav;
         else if (eff < int'(cfg_ratio) + 1) begin
            m_own = fav; nxt = eff + 1;
         end else begin
            m_own = 3 - fav; nxt = 0;
         end
      end else if (tx_req) m_own = 1;
      else if (rx_req) m_own = 2;
      m_cnt = nxt;
      m_fix_prev = cfg_fixed;
      m_rat_prev = cfg_ratio;
   endtask

   // one clock: model follows the edge, grants compared at the falling edge
   task automatic tick(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(tag, dut_owner(), m_own);
   endtask

   // both sides request until one is granted, then its owner pulses done
   task automatic contend_once(output int who);
      tx_req = 1'b1; rx_req = 1'b1;
      who = 0;
      for (int i = 0; i < 4 && who == 0; i++) begin
         tick("R4");
         who = dut_owner();
      end
      if (who == 1) tx_done = 1'b1; else rx_done = 1'b1;
      tick("R3");
      tx_done = 1'b0; rx_done = 1'b0;
   endtask

   // set a configuration and clear the counter with a mode toggle on an idle bus
   task automatic setup(input bit fixed, input bit txfav, input logic [1:0] k);
      tx_req = 1'b0; rx_req = 1'b0;
      cfg_fixed = ~fixed; cfg_tx_fav = txfav; cfg_ratio = k;
      tick("R9");
      cfg_fixed = fixed;
      tick("R9");
   endtask

   task automatic run_pattern(input string tag, input bit fixed, input bit txfav,
                              input logic [1:0] k, input int len);
      int who;
      setup(fixed, txfav, k);
      for (int n = 0; n < len; n++) begin
         contend_once(who);
         check(tag, who, exp_winner(n, fixed, txfav, int'(k)));
      end
   endtask

   initial begin
      int who;
      void'($urandom(32'd20240613));

      // R1: grants low through reset
      rst_n = 1'b0;
      tick("R1");
      tick("R1");
      check("R1", int'(tx_gnt) + int'(rx_gnt), 0);
      rst_n = 1'b1;
      cfg_tx_fav = 1'b1;
      tick("R1");
      // R1: first contended decision after reset goes to the favoured side
      contend_once(who);
      check("R1", who, 1);
      contend_once(who);
      check("R1", who, 2);

      // R7: every ratio code, both favoured sides
      run_pattern("R7", 1'b0, 1'b0, 2'd0, 4);
      run_pattern("R7", 1'b0, 1'b1, 2'd1, 6);
      run_pattern("R7", 1'b0, 1'b0, 2'd2, 8);
      run_pattern("R7", 1'b0, 1'b1, 2'd3, 10);
      // R5 and R6: fixed mode, ratio ignored
      run_pattern("R5", 1'b1, 1'b0, 2'd3, 5);
      run_pattern("R6", 1'b1, 1'b1, 2'd0, 5);
      setup(1'b1, 1'b1, 2'd0);
      cfg_ratio = 2'd2;
      contend_once(who);
      check("R5", who, 1);

      // R2: lone request granted on the next edge
      setup(1'b0, 1'b0, 2'd0);
      tx_req = 1'b1;
      tick("R2");
      check("R2", dut_owner(), 1);
      tx_req = 1'b0;
      // R3: foreign done ignored, own done releases
      rx_done = 1'b1;
      tick("R3");
      tick("R3");
      check("R3", int'(tx_gnt), 1);
      rx_done = 1'b0; tx_done = 1'b1;
      tick("R3");
      check("R3", int'(tx_gnt), 0);
      tx_done = 1'b0;
      // R4: release cycle is idle, a waiting request is served one cycle later
      rx_req = 1'b1;
      tick("R4");
      check("R4", dut_owner(), 2);
      rx_done = 1'b1;
      tick("R4");
      check("R4", dut_owner(), 0);
      rx_done = 1'b0; rx_req = 1'b0;
      tick("R4");

      // R8: a lone grant between contended ones leaves the count alone
      setup(1'b0, 1'b0, 2'd1);
      contend_once(who);
      check("R8", who, 2);
      rx_req = 1'b0; tx_req = 1'b1;
      tick("R8");
      check("R8", dut_owner(), 1);
      tx_done = 1'b1;
      tick("R8");
      tx_done = 1'b0;
      contend_once(who);
      check("R8", who, 2);
      contend_once(who);
      check("R8", who, 1);

      // R9: ratio change in the same cycle as a contended decision
      setup(1'b0, 1'b0, 2'd3);
      contend_once(who);
      contend_once(who);
      cfg_ratio = 2'd1;
      contend_once(who);
      check("R9", who, 2);
      contend_once(who);
      check("R9", who, 2);
      contend_once(who);
      check("R9", who, 1);

      // random phase against the bench model
      tx_req = 1'b0; rx_req = 1'b0;
      for (int c = 0; c < 4000; c++) begin
         tx_req  = ($urandom % 4) != 0;
         rx_req  = ($urandom % 4) != 0;
         tx_done = ($urandom % 3) == 0;
         rx_done = ($urandom % 3) == 0;
         if (($urandom % 40) == 0) cfg_ratio = 2'($urandom);
         if (($urandom % 60) == 0) cfg_fixed = ~cfg_fixed;
         if (($urandom % 50) == 0) cfg_tx_fav = ~cfg_tx_fav;
         tick("R7");
      end

      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule